// File: doc/BRIEF.md
# UART FIFO Control with Receive Trigger Levels

This block holds the receive and transmit character queues of a 16550-class serial port. Characters arrive from the receive shift register together with three error flags (parity, framing, break). The block stores them in order, shows the oldest one on the read-data port, and pops it when the host reads the receive buffer. The transmit side is a plain queue that the host fills and the transmit shift register drains.

A byte-wide, write-only control register switches queue mode on or off, clears either queue and picks the receive trigger level. With queue mode off, each side holds a single character. The block drives the queue-related line-status bits: data ready, overrun, the head character's error flags and an aggregate queue-error flag. It also raises two requests for the interrupt unit. One fires when the receive level reaches the trigger. The other fires when the receive queue has gone idle for a number of character times.

The idle timer is a three-state machine:
- `TO_IDLE`: the queue is empty or disabled. It moves to `TO_WAIT` when queue mode is on and data is present.
- `TO_WAIT`: counts character ticks. Any receive push or pop restarts the count. The tick that completes the limit moves it to `TO_FIRED`.
- `TO_FIRED`: raises the timeout request. A push or pop returns it to `TO_WAIT`.

Both `TO_WAIT` and `TO_FIRED` fall back to `TO_IDLE` on an empty queue, a disable or a receive clear.

Top module: `serial_fifo_unit`

## Requirements
- R1: After reset both queues are empty and queue mode is off. The trigger code is 00 and the overrun flag is clear, so `ls_ready`, `rda_req` and `cto_req` are 0 and `tx_empty` is 1.
- R2: Control bit 0 sets queue mode (shown on `fifo_on`). Any control write whose bit 0 differs from the current mode empties both queues.
- R3: In a control write with bit 0 = 1, bit 1 empties the receive queue, bit 2 empties the transmit queue and bits 7:6 load the trigger code. Bits 1 and 2 act only in that write. In a write with bit 0 = 0, bits 1 and 2 have no effect.
- R4: With queue mode on, each queue holds DEPTH (16) characters and returns them in arrival order. With it off, each queue holds one character.
- R5: With queue mode on, `rda_req` is 1 while the receive level is at least the trigger: code 00 = 1, 01 = 4, 10 = 8, 11 = 14 characters. With it off, `rda_req` is 1 while a character is held.
- R6: `ls_ready` is 1 whenever the receive queue holds a character. `rx_rdata` shows the oldest character, and `rx_pop` removes it.
- R7: A receive push into a full queue without a pop in the same cycle discards the new character and leaves the stored ones untouched. It also sets `ls_overrun`, which stays set until an `lsr_rd` cycle. A new overrun in that same cycle wins.
- R8: `ls_perr`, `ls_ferr` and `ls_brk` show the flags stored with the oldest receive character, and are 0 when the queue is empty.
- R9: `ls_fifo_err` is 1 while any stored receive character carries at least one error flag.
- R10: With queue mode on and the receive queue non-empty, `cto_req` rises on the 4th `char_tick` that follows with no receive push or pop. A push or pop drops it and restarts the count. It never rises with queue mode off or an empty queue.
- R11: `tx_push` stores a character and `tx_rdata` shows the oldest one, which `tx_pop` removes. `tx_empty` and `tx_full` report the level against the current capacity, and a push into a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write value |
| rx_push | input | 1 | Receive shift register delivers a character |
| rx_char | input | 8 | Delivered character |
| rx_perr | input | 1 | Parity error for the delivered character |
| rx_ferr | input | 1 | Framing error for the delivered character |
| rx_brk | input | 1 | Break seen for the delivered character |
| rx_pop | input | 1 | Host reads the receive buffer |
| rx_rdata | output | 8 | Oldest received character |
| lsr_rd | input | 1 | Host reads the line-status register |
| tx_push | input | 1 | Host writes a transmit character |
| tx_char | input | 8 | Transmit character |
| tx_pop | input | 1 | Transmit shift register takes a character |
| tx_rdata | output | 8 | Oldest transmit character |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at capacity |
| char_tick | input | 1 | One character time has elapsed |
| fifo_on | output | 1 | Queue mode active |
| ls_ready | output | 1 | Line status: data ready |
| ls_overrun | output | 1 | Line status: overrun |
| ls_perr | output | 1 | Line status: parity error of head character |
| ls_ferr | output | 1 | Line status: framing error of head character |
| ls_brk | output | 1 | Line status: break of head character |
| ls_fifo_err | output | 1 | Line status: some stored character has an error |
| rda_req | output | 1 | Receive data available request |
| cto_req | output | 1 | Character timeout request |

## Verification
The bench sweeps all four trigger codes, filling the receive queue one character at a time and checking the request after every push. A design with an off-by-one threshold raises `rda_req` one character early or late. It then overfills the queue and drains it, so a design that overwrites the tail on overrun returns a wrong character. Control writes are applied with and without bit 0 and across mode changes. This catches clear bits that act while the mode is off, clear bits that linger into later writes, and a mode toggle that leaves stale characters behind. The idle timer is probed on the third and fourth tick, after a pop, after a restarting push and with the mode off. Error patterns placed behind clean characters show whether the aggregate error flag tracks the whole queue or only its head.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_WAIT  = 2'd1,
        TO_FIRED = 2'd2
    } to_state_t;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    // Trigger level in characters for a 2-bit code, scaled to the depth.
    function automatic int unsigned trig_level(input logic [1:0] code,
                                               input int unsigned depth);
        unique case (code)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction
endpackage

// File: rtl/sfu_ctrl_reg.sv
module sfu_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       en,
    output logic [1:0] trig_code,
    output logic       rx_flush,
    output logic       tx_flush
);
    timeunit 1ns;
    timeprecision 1ps;

    logic       en_q;
    logic [1:0] trig_q;
    logic       mode_flip;
    logic       qualified;
    logic       unused_bits;

    assign unused_bits = ^wdata[5:3];

    // A flip of the mode bit drains both sides; the other bits need bit 0.
    assign mode_flip = wr && (wdata[0] != en_q);
    assign qualified = wr && wdata[0];
    assign rx_flush  = mode_flip || (qualified && wdata[1]);
    assign tx_flush  = mode_flip || (qualified && wdata[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trig_q <= 2'd0;
        end else begin
            if (wr)        en_q   <= wdata[0];
            if (qualified) trig_q <= wdata[7:6];
        end
    end

    assign en        = en_q;
    assign trig_code = trig_q;
endmodule

// File: rtl/sfu_queue.sv
module sfu_queue #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          cap_one,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          accepted,
    output logic          removed
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] lvl_q;
    logic          empty, take, put;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + AW'(1);
    endfunction

    assign empty = (lvl_q == '0);
    assign full  = cap_one ? !empty : (lvl_q == CW'(DEPTH));
    assign take  = pop && !empty && !flush;
    assign put   = push && (!full || take) && !flush;

    always_ff @(posedge clk) begin
        if (put) store[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else if (flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (put)  wr_q <= step(wr_q);
            if (take) rd_q <= step(rd_q);
            unique case ({put, take})
                2'b10:   lvl_q <= lvl_q + CW'(1);
                2'b01:   lvl_q <= lvl_q - CW'(1);
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    assign dout     = store[rd_q];
    assign level    = lvl_q;
    assign accepted = put;
    assign removed  = take;
endmodule

// File: rtl/sfu_timeout.sv
module sfu_timeout #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic nonempty,
    input  logic activity,
    input  logic clear,
    input  logic tick,
    output logic fire
);
    timeunit 1ns;
    timeprecision 1ps;
    import sfu_pkg::*;

    localparam int unsigned TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(LIMIT - 1);

    to_state_t     st_q, st_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          drop;

    assign drop = !enable || !nonempty || clear;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            TO_IDLE: begin
                if (!drop) begin
                    st_d  = TO_WAIT;
                    cnt_d = '0;
                end
            end
            TO_WAIT: begin
                if (drop) begin
                    st_d = TO_IDLE;
                end else if (activity) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST_TICK) st_d = TO_FIRED;
                    else                    cnt_d = cnt_q + TW'(1);
                end
            end
            TO_FIRED: begin
                if (drop) begin
                    st_d = TO_IDLE;
                end else if (activity) begin
                    st_d  = TO_WAIT;
                    cnt_d = '0;
                end
            end
            default: st_d = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TO_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        fire = (st_q == TO_FIRED);
    end
endmodule

// File: rtl/serial_fifo_unit.sv
module serial_fifo_unit #(
    parameter int unsigned DEPTH         = 16,
    parameter int unsigned TIMEOUT_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       rx_push,
    input  logic [7:0] rx_char,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       rx_pop,
    output logic [7:0] rx_rdata,
    input  logic       lsr_rd,
    input  logic       tx_push,
    input  logic [7:0] tx_char,
    input  logic       tx_pop,
    output logic [7:0] tx_rdata,
    output logic       tx_empty,
    output logic       tx_full,
    input  logic       char_tick,
    output logic       fifo_on,
    output logic       ls_ready,
    output logic       ls_overrun,
    output logic       ls_perr,
    output logic       ls_ferr,
    output logic       ls_brk,
    output logic       ls_fifo_err,
    output logic       rda_req,
    output logic       cto_req
);
    timeunit 1ns;
    timeprecision 1ps;
    import sfu_pkg::*;

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned EW = $bits(rx_entry_t);

    logic          en, rx_flush, tx_flush;
    logic [1:0]    trig_code;
    rx_entry_t     rx_in, rx_head;
    logic [EW-1:0] rx_head_bits;
    logic [CW-1:0] rx_count, tx_count, err_cnt_q, trig_n;
    logic          rx_full, rx_accept, rx_removed;
    logic          unused_tx_put, unused_tx_take;
    logic          ovr_q, err_in, err_out;

    sfu_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl_wr),
        .wdata     (ctl_wdata),
        .en        (en),
        .trig_code (trig_code),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush)
    );

    assign rx_in = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_char};

    sfu_queue #(.W(EW), .DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_flush),
        .cap_one  (!en),
        .push     (rx_push),
        .din      (rx_in),
        .pop      (rx_pop),
        .dout     (rx_head_bits),
        .level    (rx_count),
        .full     (rx_full),
        .accepted (rx_accept),
        .removed  (rx_removed)
    );

    sfu_queue #(.W(CHAR_W), .DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tx_flush),
        .cap_one  (!en),
        .push     (tx_push),
        .din      (tx_char),
        .pop      (tx_pop),
        .dout     (tx_rdata),
        .level    (tx_count),
        .full     (tx_full),
        .accepted (unused_tx_put),
        .removed  (unused_tx_take)
    );

    sfu_timeout #(.LIMIT(TIMEOUT_CHARS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (en),
        .nonempty (rx_count != '0),
        .activity (rx_push || rx_pop),
        .clear    (rx_flush),
        .tick     (char_tick),
        .fire     (cto_req)
    );

    assign rx_head = rx_head_bits;

    // Overrun: a dropped push that was not swallowed by a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  ovr_q <= 1'b0;
        else if (rx_push && !rx_accept && !rx_flush) ovr_q <= 1'b1;
        else if (lsr_rd)                             ovr_q <= 1'b0;
    end

    // Running tally of stored characters that carry an error flag.
    assign err_in  = rx_accept  && (rx_perr || rx_ferr || rx_brk);
    assign err_out = rx_removed && (rx_head.perr || rx_head.ferr || rx_head.brk);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        err_cnt_q <= '0;
        else if (rx_flush) err_cnt_q <= '0;
        else begin
            unique case ({err_in, err_out})
                2'b10:   err_cnt_q <= err_cnt_q + CW'(1);
                2'b01:   err_cnt_q <= err_cnt_q - CW'(1);
                default: err_cnt_q <= err_cnt_q;
            endcase
        end
    end

    assign trig_n = CW'(trig_level(trig_code, DEPTH));

    always_comb begin
        fifo_on     = en;
        ls_ready    = (rx_count != '0);
        rx_rdata    = rx_head.data;
        ls_perr     = ls_ready && rx_head.perr;
        ls_ferr     = ls_ready && rx_head.ferr;
        ls_brk      = ls_ready && rx_head.brk;
        ls_overrun  = ovr_q;
        ls_fifo_err = (err_cnt_q != '0);
        rda_req     = en ? (rx_count >= trig_n) : ls_ready;
        tx_empty    = (tx_count == '0);
    end
endmodule

// File: rtl/sfu_checks.sv
module sfu_checks #(
    parameter int unsigned CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic [7:0]    ctl_wdata,
    input logic          fifo_on,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          lsr_rd,
    input logic          ls_ready,
    input logic          ls_overrun,
    input logic          ls_perr,
    input logic          ls_ferr,
    input logic          ls_brk,
    input logic          ls_fifo_err,
    input logic          rda_req,
    input logic          cto_req,
    input logic          tx_empty,
    input logic [CW-1:0] rx_level
);
    timeunit 1ns;
    timeprecision 1ps;

    // R2
    mode_flip_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (ctl_wdata[0] != fifo_on)) |=> (!ls_ready && tx_empty));

    // R4
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (rx_level <= CW'(1)));

    // R5
    holding_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (rda_req == ls_ready));

    // R7
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_overrun) |-> $past(rx_push));

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_overrun && !lsr_rd) |=> ls_overrun);

    // R9
    head_err_in_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_perr || ls_ferr || ls_brk) |-> ls_fifo_err);

    // R10
    timeout_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cto_req |-> (ls_ready && fifo_on));

    // R10
    timeout_read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cto_req && rx_pop) |=> !cto_req);
endmodule

bind serial_fifo_unit sfu_checks #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .fifo_on     (fifo_on),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .lsr_rd      (lsr_rd),
    .ls_ready    (ls_ready),
    .ls_overrun  (ls_overrun),
    .ls_perr     (ls_perr),
    .ls_ferr     (ls_ferr),
    .ls_brk      (ls_brk),
    .ls_fifo_err (ls_fifo_err),
    .rda_req     (rda_req),
    .cto_req     (cto_req),
    .tx_empty    (tx_empty),
    .rx_level    (rx_count)
);

// File: tb/serial_fifo_unit_test.sv
module serial_fifo_unit_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_rdata;
    logic       lsr_rd = 1'b0;
    logic       tx_push = 1'b0;
    logic [7:0] tx_char = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_rdata;
    logic       tx_empty, tx_full;
    logic       char_tick = 1'b0;
    logic       fifo_on, ls_ready, ls_overrun, ls_perr, ls_ferr, ls_brk;
    logic       ls_fifo_err, rda_req, cto_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    bit         m_en = 0;
    int         m_trig = 0;
    bit         m_ovr = 0;
    logic [10:0] rxq[$];
    logic [7:0]  txq[$];

    always #2 clk = ~clk;

    serial_fifo_unit uut (.*);

    task automatic chk(input string where, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", where, what, act, exp);
        end
    endtask

    function automatic int cap();
        return m_en ? DEPTH : 1;
    endfunction

    function automatic int trig_bytes(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit any_err();
        foreach (rxq[i]) if (rxq[i][10:8] != 3'b000) return 1;
        return 0;
    endfunction

    task automatic verify(input string where);
        int sz;
        sz = rxq.size();
        chk(where, "R6 ls_ready", ls_ready, sz > 0);
        if (sz > 0) begin
            chk(where, "R6 rx_rdata", rx_rdata, rxq[0][7:0]);
            chk(where, "R8 ls_perr", ls_perr, rxq[0][8]);
            chk(where, "R8 ls_ferr", ls_ferr, rxq[0][9]);
            chk(where, "R8 ls_brk", ls_brk, rxq[0][10]);
        end else begin
            chk(where, "R8 flags when empty", {ls_brk, ls_ferr, ls_perr}, 0);
        end
        chk(where, "R7 ls_overrun", ls_overrun, m_ovr);
        chk(where, "R9 ls_fifo_err", ls_fifo_err, any_err());
        chk(where, "R5 rda_req", rda_req, m_en ? (sz >= trig_bytes(m_trig)) : (sz >= 1));
        chk(where, "R11 tx_empty", tx_empty, txq.size() == 0);
        chk(where, "R11 tx_full", tx_full, txq.size() >= cap());
        if (txq.size() > 0) chk(where, "R11 tx_rdata", tx_rdata, txq[0]);
        chk(where, "R2 fifo_on", fifo_on, m_en);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        if (v[0] != m_en) begin rxq.delete(); txq.delete(); end
        m_en = v[0];
        if (v[0]) begin
            if (v[1]) rxq.delete();
            if (v[2]) txq.delete();
            m_trig = v[7:6];
        end
    endtask

    task automatic rx_in(input logic [7:0] d, input logic [2:0] f);
        rx_push = 1'b1; rx_char = d; {rx_brk, rx_ferr, rx_perr} = f;
        @(negedge clk);
        rx_push = 1'b0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
        if (rxq.size() < cap()) rxq.push_back({f, d});
        else m_ovr = 1;
    endtask

    task automatic rx_rd();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        if (rxq.size() > 0) void'(rxq.pop_front());
    endtask

    task automatic status_rd();
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
        m_ovr = 0;
    endtask

    task automatic tx_in(input logic [7:0] d);
        tx_push = 1'b1; tx_char = d;
        @(negedge clk);
        tx_push = 1'b0;
        if (txq.size() < cap()) txq.push_back(d);
    endtask

    task automatic tx_out();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        if (txq.size() > 0) void'(txq.pop_front());
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            @(negedge clk);
            char_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        verify("R1 reset");
        chk("R1 reset", "R10 cto_req", cto_req, 0);

        ctl_write(8'h01);
        verify("R2 enable");

        // R4 R5 R6 R7: every trigger code, fill to depth, overrun, drain
        for (int code = 0; code < 4; code++) begin
            ctl_write(8'({code[1:0], 6'b000011}));
            verify("R3 trigger load");
            for (int n = 1; n <= DEPTH; n++) begin
                rx_in(8'(code * 32 + n), 3'b000);
                verify("R5 fill");
            end
            rx_in(8'hEE, 3'b000);
            verify("R7 overrun");
            rx_in(8'hEF, 3'b000);
            verify("R7 overrun held");
            status_rd();
            verify("R7 status read clears");
            for (int n = 0; n < DEPTH; n++) begin
                rx_rd();
                verify("R4 drain order");
            end
        end

        // R8 R9: errored characters behind clean ones
        ctl_write(8'h03);
        for (int k = 0; k < 8; k++) rx_in(8'(8'hA0 + k), (k == 1) ? 3'd1 : (k == 4) ? 3'd6 : (k == 6) ? 3'd4 : 3'd0);
        for (int k = 0; k < 8; k++) rx_in(8'(8'hB0 + k), 3'(k));
        verify("R9 loaded");
        for (int k = 0; k < 16; k++) begin
            rx_rd();
            verify("R8 R9 drain");
        end

        // R3: clear bits with mode on, self-clearing, ignored with mode off
        for (int k = 0; k < 3; k++) begin rx_in(8'(k + 1), 3'b000); tx_in(8'(k + 9)); end
        ctl_write(8'h03);
        verify("R3 rx clear only");
        ctl_write(8'h05);
        verify("R3 tx clear");
        rx_in(8'h41, 3'b000); tx_in(8'h42);
        ctl_write(8'h01);
        verify("R3 no lingering clear");
        ctl_write(8'h00);
        verify("R2 disable drains");
        rx_in(8'h55, 3'b010); tx_in(8'h66);
        ctl_write(8'hC6);
        verify("R3 ignored while off");

        // R4: single slot with mode off
        rx_in(8'h77, 3'b000);
        verify("R4 single rx slot");
        tx_in(8'h88);
        verify("R4 single tx slot");
        status_rd();
        rx_rd(); tx_out();
        verify("R4 single slot emptied");
        rx_in(8'h12, 3'b000);
        verify("R4 refill single slot");

        // R2: mode toggles drain both queues
        tx_in(8'h34);
        ctl_write(8'h41);
        verify("R2 enable drains");
        for (int k = 0; k < 5; k++) begin rx_in(8'(k + 40), 3'b000); tx_in(8'(k + 50)); end
        verify("R2 loaded");
        ctl_write(8'h00);
        verify("R2 disable drains loaded");

        // R11: transmit queue order and full drop
        ctl_write(8'h01);
        for (int k = 0; k <= DEPTH; k++) begin
            tx_in(8'(k * 7 + 3));
            verify("R11 tx fill");
        end
        for (int k = 0; k < DEPTH; k++) begin
            tx_out();
            verify("R11 tx drain");
        end

        // R10: idle timeout
        rx_in(8'h21, 3'b000); rx_in(8'h22, 3'b000);
        repeat (2) @(negedge clk);
        ticks(3);
        chk("R10 three ticks", "cto_req", cto_req, 0);
        ticks(1);
        chk("R10 fourth tick", "cto_req", cto_req, 1);
        rx_rd();
        chk("R10 pop drops", "cto_req", cto_req, 0);
        ticks(3);
        chk("R10 after pop three", "cto_req", cto_req, 0);
        ticks(1);
        chk("R10 after pop four", "cto_req", cto_req, 1);
        rx_in(8'h23, 3'b000);
        chk("R10 push drops", "cto_req", cto_req, 0);
        ticks(3);
        rx_in(8'h24, 3'b000);
        ticks(3);
        chk("R10 push restarts", "cto_req", cto_req, 0);
        ticks(1);
        chk("R10 restart expiry", "cto_req", cto_req, 1);
        verify("R10 data intact");
        for (int k = 0; k < 3; k++) rx_rd();
        ticks(5);
        chk("R10 empty queue", "cto_req", cto_req, 0);
        ctl_write(8'h00);
        rx_in(8'h25, 3'b000);
        repeat (2) @(negedge clk);
        ticks(6);
        chk("R10 mode off", "cto_req", cto_req, 0);
        verify("R10 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule